// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the instruction fetch address register and answers, in the same cycle as the fetch address is presented, two questions together. The first is whether the fetched word is a branch it has seen before. The second is where fetch should go next.

It is a direct-mapped table. Each slot remembers three things: the complete address of one branch, that branch's last known target, and a 2-bit saturating direction counter. A lookup matches only when the remembered address equals the fetch address exactly. A hit whose counter leans taken steers fetch to the stored target. Every other case falls through to the sequential address, fetch address plus 4.

A separate resolve port, driven from later in the pipeline once a branch's real outcome and target are known, trains the table. A taken branch that is absent claims its slot, which may evict another branch. A present branch has its counter moved and its target refreshed. Changes made through the resolve port become visible to lookups on the next clock.

Top module: `tgtpred`

## Requirements
- R1: After reset every slot is empty, so every fetch address reads as a miss until the resolve port writes something.
- R2: A hit requires that the whole fetch address, every bit except the slot index bits [IDX_W+1:2], equals the address stored in the slot. A different address that maps to the same slot is a miss.
- R3: On a hit whose counter is 2 or 3, predTaken is 1, predTarget is the stored target, and nextPc equals that target.
- R4: On a hit whose counter is 0 or 1, predHit is 1, predTaken is 0, and nextPc is fetchPc+4.
- R5: On a miss, predHit and predTaken are 0 and nextPc is fetchPc+4.
- R6: A resolved taken branch that misses is written into its slot with its address, its actual target and counter value 2 (weakly taken), replacing whatever the slot held.
- R7: A resolved not-taken branch that misses leaves the table unchanged.
- R8: A resolved branch that hits moves its counter one step toward 3 if taken and one step toward 0 if not taken, saturating at both ends.
- R9: A resolved branch that hits has its stored target replaced by the resolved target, whatever its direction.
- R10: Lookups are combinational on the current table. A resolve write takes effect at the next rising clock edge, so a lookup in the same cycle as the resolve sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchPc | input | ADDR_W | Address being fetched this cycle |
| predHit | output | 1 | fetchPc matches a stored branch |
| predTaken | output | 1 | Hit and counter predicts taken |
| predTarget | output | ADDR_W | Stored target of the matching slot |
| nextPc | output | ADDR_W | Predicted next fetch address |
| resValid | input | 1 | A branch outcome is presented this cycle |
| resPc | input | ADDR_W | Address of the resolved branch |
| resTaken | input | 1 | Actual direction of the resolved branch |
| resTarget | input | ADDR_W | Actual target of the resolved branch |

## Verification
The bench builds the block with ADDR_W=10 and ENTRIES=4. With these values the whole aligned address space is only 256 words, and it can be swept after reset. Each slot is contested by many aliasing addresses, so evictions and tag mismatches happen constantly in a long pseudo-random run of resolves and lookups. Directed phases walk one counter through both saturation ends and check the same-cycle ordering of a write and a lookup. A small arithmetic model in the bench supplies the expected values.

// File: rtl/tgtpred_pkg.sv
`timescale 1ns/1ps
package tgtpred_pkg;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'd2;

  // strobes from the control to the datapath, one resolve write per cycle
  typedef struct packed {
    logic       wrEn;     // write the slot selected by the resolve address
    logic       ldTag;    // (re)claim the slot: set valid and load the address tag
    logic [1:0] ctrNext;  // counter value to write
  } tpStrobe_t;

  function automatic logic [1:0] ctrStep(input logic [1:0] cur, input logic taken);
    logic [1:0] res;
    if (taken) res = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else       res = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/tgtpred_ctrl.sv
`timescale 1ns/1ps
module tgtpred_ctrl
  import tgtpred_pkg::*;
(
  input  logic       resValid,
  input  logic       resTaken,
  input  logic       rsHit,
  input  logic [1:0] rsCtr,
  output tpStrobe_t  strobe
);

  // R6: a taken miss claims the slot; R7: a not-taken miss writes nothing
  // R8/R9: any hit trains the counter and refreshes the target
  always_comb begin
    strobe.wrEn    = resValid && (rsHit || resTaken);
    strobe.ldTag   = !rsHit;
    strobe.ctrNext = rsHit ? ctrStep(rsCtr, resTaken) : CTR_WEAK_TAKEN;
  end

endmodule

// File: rtl/tgtpred_dpath.sv
`timescale 1ns/1ps
module tgtpred_dpath
  import tgtpred_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lkPc,
  input  logic [ADDR_W-1:0] rsPc,
  input  logic [ADDR_W-1:0] rsTarget,
  input  tpStrobe_t         strobe,
  output logic              lkHit,
  output logic [1:0]        lkCtr,
  output logic [ADDR_W-1:0] lkTarget,
  output logic              rsHit,
  output logic [1:0]        rsCtr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              slotVld [ENTRIES];
  logic [TAG_W-1:0]  slotTag [ENTRIES];
  logic [ADDR_W-1:0] slotTgt [ENTRIES];
  logic [1:0]        slotCtr [ENTRIES];

  logic [IDX_W-1:0] lkIdx, rsIdx;
  logic [TAG_W-1:0] lkTag, rsTag;

  // index from the word address; tag keeps every other address bit
  assign lkIdx = lkPc[IDX_W+1:2];
  assign rsIdx = rsPc[IDX_W+1:2];
  assign lkTag = {lkPc[ADDR_W-1:IDX_W+2], lkPc[1:0]};
  assign rsTag = {rsPc[ADDR_W-1:IDX_W+2], rsPc[1:0]};

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic selWr;
      assign selWr = strobe.wrEn && (rsIdx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    slotVld[e] <= 1'b0;
        else if (selWr && strobe.ldTag) slotVld[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (selWr) begin
          if (strobe.ldTag) slotTag[e] <= rsTag;
          slotTgt[e] <= rsTarget;
          slotCtr[e] <= strobe.ctrNext;
        end
      end
    end
  endgenerate

  // fetch-side read port
  always_comb begin
    lkHit    = slotVld[lkIdx] && (slotTag[lkIdx] == lkTag);
    lkCtr    = slotCtr[lkIdx];
    lkTarget = slotTgt[lkIdx];
  end

  // resolve-side read port
  always_comb begin
    rsHit = slotVld[rsIdx] && (slotTag[rsIdx] == rsTag);
    rsCtr = slotCtr[rsIdx];
  end

endmodule

// File: rtl/tgtpred.sv
`timescale 1ns/1ps
module tgtpred
  import tgtpred_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              predHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget,
  output logic [ADDR_W-1:0] nextPc,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resPc,
  input  logic              resTaken,
  input  logic [ADDR_W-1:0] resTarget
);

  tpStrobe_t         strobe;
  logic              lkHit, rsHit;
  logic [1:0]        lkCtr, rsCtr;
  logic [ADDR_W-1:0] lkTarget;

  tgtpred_ctrl ctrl_i (
    .resValid (resValid),
    .resTaken (resTaken),
    .rsHit    (rsHit),
    .rsCtr    (rsCtr),
    .strobe   (strobe)
  );

  tgtpred_dpath #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lkPc     (fetchPc),
    .rsPc     (resPc),
    .rsTarget (resTarget),
    .strobe   (strobe),
    .lkHit    (lkHit),
    .lkCtr    (lkCtr),
    .lkTarget (lkTarget),
    .rsHit    (rsHit),
    .rsCtr    (rsCtr)
  );

  assign predHit    = lkHit;
  assign predTaken  = lkHit && lkCtr[1];
  assign predTarget = lkTarget;
  assign nextPc     = predTaken ? lkTarget : fetchPc + ADDR_W'(4);

endmodule

// File: rtl/tgtpred_chk.sv
`timescale 1ns/1ps
module tgtpred_chk #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              predHit,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predTarget,
  input logic [ADDR_W-1:0] nextPc,
  input logic              resValid,
  input logic [ADDR_W-1:0] resPc,
  input logic              resTaken,
  input logic [ADDR_W-1:0] resTarget
);

  logic pastOk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  // R4/R5: without a taken prediction fetch runs sequentially
  a_r5_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !predTaken |-> nextPc == fetchPc + ADDR_W'(4));

  // R3: a taken prediction needs a hit and steers fetch to the target
  a_r3_taken_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    predTaken |-> (predHit && nextPc == predTarget));

  // R6/R9: a taken resolve leaves that address present with its target
  a_r6_taken_present: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    ($past(resValid && resTaken) && fetchPc == $past(resPc))
      |-> (predHit && predTarget == $past(resTarget)));

  // R7: a not-taken resolve that missed keeps the address absent
  a_r7_no_alloc: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    ($past(resValid && !resTaken && fetchPc == resPc && !predHit) && fetchPc == $past(fetchPc))
      |-> !predHit);

  // R9: a hit resolve refreshes the target whatever the direction
  a_r9_target_refresh: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    ($past(resValid && fetchPc == resPc && predHit) && fetchPc == $past(fetchPc))
      |-> (predHit && predTarget == $past(resTarget)));

  // R8: a strong-side counter moved toward its own side stays on that side
  a_r8_ctr_hold_taken: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    ($past(resValid && resTaken && fetchPc == resPc && predTaken) && fetchPc == $past(fetchPc))
      |-> predTaken);

  a_r8_ctr_hold_not_taken: assert property (@(posedge clk) disable iff (!rst_n || !pastOk)
    ($past(resValid && !resTaken && fetchPc == resPc && predHit && !predTaken) && fetchPc == $past(fetchPc))
      |-> (predHit && !predTaken));

endmodule

bind tgtpred tgtpred_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetchPc    (fetchPc),
  .predHit    (predHit),
  .predTaken  (predTaken),
  .predTarget (predTarget),
  .nextPc     (nextPc),
  .resValid   (resValid),
  .resPc      (resPc),
  .resTaken   (resTaken),
  .resTarget  (resTarget)
);

// File: tb/tgtpred_tb_top.sv
`timescale 1ns/1ps
module tgtpred_tb_top;

  localparam int AW  = 10;
  localparam int NE  = 4;
  localparam int IW  = 2;
  localparam int TW  = AW - IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic          predHit, predTaken;
  logic [AW-1:0] predTarget, nextPc;
  logic          resValid = 1'b0;
  logic [AW-1:0] resPc = '0;
  logic          resTaken = 1'b0;
  logic [AW-1:0] resTarget = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of the table
  bit            mVld [NE];
  logic [TW-1:0] mTag [NE];
  logic [AW-1:0] mTgt [NE];
  logic [1:0]    mCtr [NE];

  always #2.5 clk = ~clk;

  tgtpred #(.ADDR_W(AW), .ENTRIES(NE)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchPc    (fetchPc),
    .predHit    (predHit),
    .predTaken  (predTaken),
    .predTarget (predTarget),
    .nextPc     (nextPc),
    .resValid   (resValid),
    .resPc      (resPc),
    .resTaken   (resTaken),
    .resTarget  (resTarget)
  );

  function automatic int idxOf(input logic [AW-1:0] a);
    return int'(a[IW+1:2]);
  endfunction

  function automatic logic [TW-1:0] tagOf(input logic [AW-1:0] a);
    return {a[AW-1:IW+2], a[1:0]};
  endfunction

  // one cycle: drive at the falling edge, check lookup, then apply the resolve
  task automatic cyc(input logic [AW-1:0] fpc, input bit rv, input logic [AW-1:0] rpc,
                     input bit rt, input logic [AW-1:0] rtg, input string req);
    bit eh, et, rh;
    int fi, ri;
    logic [AW-1:0] enx;
    string tagName;
    @(negedge clk);
    fetchPc = fpc; resValid = rv; resPc = rpc; resTaken = rt; resTarget = rtg;
    #1;
    fi  = idxOf(fpc);
    eh  = mVld[fi] && (mTag[fi] == tagOf(fpc));
    et  = eh && mCtr[fi][1];
    enx = et ? mTgt[fi] : fpc + AW'(4);
    tagName = req;
    if (tagName == "") tagName = !eh ? "R5" : (et ? "R3" : "R4");
    nChecks++;
    if ({predHit, predTaken, nextPc} !== {eh, et, enx}) begin
      nFails++;
      $display("FAIL %s pc=%h hit/taken/next act=%b/%b/%h exp=%b/%b/%h",
               tagName, fpc, predHit, predTaken, nextPc, eh, et, enx);
    end
    if (eh) begin
      nChecks++;
      if (predTarget !== mTgt[fi]) begin
        nFails++;
        $display("FAIL %s pc=%h target act=%h exp=%h", tagName, fpc, predTarget, mTgt[fi]);
      end
    end
    @(posedge clk);
    if (rv) begin
      ri = idxOf(rpc);
      rh = mVld[ri] && (mTag[ri] == tagOf(rpc));
      if (rh) begin
        mCtr[ri] = rt ? ((mCtr[ri] == 2'd3) ? 2'd3 : mCtr[ri] + 2'd1)
                      : ((mCtr[ri] == 2'd0) ? 2'd0 : mCtr[ri] - 2'd1);
        mTgt[ri] = rtg;
      end else if (rt) begin
        mVld[ri] = 1'b1; mTag[ri] = tagOf(rpc); mTgt[ri] = rtg; mCtr[ri] = 2'd2;
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pcA, pcB;
    logic [15:0]   lf;
    for (int i = 0; i < NE; i++) begin mVld[i] = 1'b0; mCtr[i] = 2'd0; end
    pcA = 10'h104;  // slot 1
    pcB = 10'h204;  // same slot, other address
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every aligned address misses after reset
    for (int k = 0; k < 256; k++) cyc(AW'(k * 4), 1'b0, '0, 1'b0, '0, "R1");

    // R7: not-taken miss is not written
    cyc(pcA, 1'b1, pcA, 1'b0, 10'h3f0, "R7");
    cyc(pcA, 1'b0, '0, 1'b0, '0, "R7");
    // R10: same-cycle lookup sees the old table; R6 allocation next cycle
    cyc(pcA, 1'b1, pcA, 1'b1, 10'h3f0, "R10");
    cyc(pcA, 1'b0, '0, 1'b0, '0, "R6");
    // R2: aliasing address misses; unaligned neighbour misses
    cyc(pcB, 1'b0, '0, 1'b0, '0, "R2");
    cyc(pcA | AW'(1), 1'b0, '0, 1'b0, '0, "R2");
    // R8/R9: walk the counter down past zero, then up past three
    for (int s = 0; s < 3; s++) begin
      cyc(pcA, 1'b1, pcA, 1'b0, AW'(10'h120 + s * 8), "R9");
      cyc(pcA, 1'b0, '0, 1'b0, '0, "R8");
    end
    for (int s = 0; s < 4; s++) begin
      cyc(pcA, 1'b1, pcA, 1'b1, AW'(10'h200 + s * 8), "R9");
      cyc(pcA, 1'b0, '0, 1'b0, '0, "R8");
    end
    // R6: taken alias replaces the slot
    cyc(pcB, 1'b1, pcB, 1'b1, 10'h0c0, "R6");
    cyc(pcA, 1'b0, '0, 1'b0, '0, "R2");
    cyc(pcB, 1'b0, '0, 1'b0, '0, "R6");

    // mixed traffic over a small address set
    lf = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] fp, rp;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fp = {4'b0, lf[1:0], lf[3:2], 2'b00};
      rp = {4'b0, lf[5:4], lf[7:6], 2'b00};
      cyc(fp, lf[8] | lf[9], rp, lf[10] ^ lf[11], {lf[15:8], 2'b00}, "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule